// File: doc/BRIEF.md
# Primitive Draw Busy-Cycle Estimator

This block predicts how long a rasteriser will be occupied by one drawing command, so that the surrounding GPU can hold its idle indication low for a realistic time. A request describes a rectangle, a line or a triangle. Rectangles and lines carry their clipped width and height. Triangles carry a pixel count that was already worked out upstream. Every request also carries the texture mode, a textured flag, a blending flag, a mask-check flag and an interlaced-skip flag.

When the block is idle, it accepts a request and works out the cost in cycles. One cycle later it presents that cost with a single-cycle valid pulse and raises `busy`. It then counts the cost down to zero. While `busy` is high it refuses any further request through `req_ready`. Rectangle cost is a per-row cost multiplied by the effective height. The per-row cost depends on the texture mode and on whether the row reaches the texture-cache reload width of 32. The result saturates at the largest value the counter can hold.

Top module: `draw_cost_estimator`

## Requirements
- R1: An untextured rectangle without blending or mask check costs width × height.
- R2: With `req_textured` high and texture mode 0 (4-bit palette), each rectangle row costs twice its width. With `req_textured` low, the texture mode has no effect on the cost.
- R3: Texture mode 1 (8-bit palette) adds (width/4)×8 to each row when the width is 32 or more, and adds width when the width is below 32.
- R4: Texture modes 2 and 3 (direct 16-bit) add (width/2)×8 to each row when the width is 32 or more, and add width when the width is below 32.
- R5: Either `req_blend` or `req_mask_check` adds (width+1)/2 to each rectangle row. Both together add it only once.
- R6: With `req_interlace_skip` high, the height used for rectangles and lines becomes height/2, but never less than 1.
- R7: A line (kind 1) costs the larger of its width and its effective height.
- R8: A triangle (kind 2 or 3) starts from `req_pixels`. Texturing doubles the count. Blending or mask check then adds (count+1)/2. Interlaced skip then halves the result.
- R9: Any cost above 2^COUNT_W−1 is reported as 2^COUNT_W−1.
- R10: A request is accepted on a rising edge when `req_valid` and `req_ready` are both high. On the next cycle `cost_valid` is high for exactly one cycle with the cost on `cost_count`, and `busy` is high.
- R11: `busy` stays high for exactly cost+1 cycles after acceptance. `req_ready` is high again on the cycle in which `busy` falls.
- R12: A request presented while `busy` is high is refused: `req_ready` is low, no `cost_valid` pulse follows, and the countdown in progress is unchanged.
- R13: After reset, `busy` and `cost_valid` are low, `req_ready` is high and `cost_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 rectangle, 1 line, 2 or 3 triangle |
| req_width | input | DIM_W | Clipped width |
| req_height | input | DIM_W | Clipped height |
| req_pixels | input | PIX_W | Precomputed triangle pixel count |
| req_texmode | input | 2 | 0 4-bit palette, 1 8-bit palette, 2/3 direct 16-bit |
| req_textured | input | 1 | Primitive is textured |
| req_blend | input | 1 | Semitransparency enabled |
| req_mask_check | input | 1 | Mask check before draw enabled |
| req_interlace_skip | input | 1 | Interlaced field skipping applies |
| cost_valid | output | 1 | One-cycle pulse marking a new cost |
| cost_count | output | COUNT_W | Computed cycle cost |
| busy | output | 1 | Countdown in progress |

## Verification
A fault in the cost arithmetic shows up on `cost_count` in the cycle right after acceptance, so each directed case checks it at that point. A fault in the countdown register does not show up in `cost_count`. It shows up only when `busy` falls: an extra or a missing decrement moves the fall by one cycle or more. For that reason every case measures the length of the busy window against cost+1. A fault in the acceptance gating shows up as a second `cost_valid` pulse, or as a lengthened busy window, while a refused request is being held on the inputs.

// File: rtl/dce_pkg.sv
// Package: shared encodings and helpers for the draw busy-cycle estimator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dce_pkg;

    // Primitive kind carried on req_kind; both upper codes mean triangle.
    typedef enum logic [1:0] {
        PRIM_RECT    = 2'b00,
        PRIM_LINE    = 2'b01,
        PRIM_TRI     = 2'b10,
        PRIM_TRI_ALT = 2'b11
    } prim_e;

    // Texture colour mode carried on req_texmode.
    typedef enum logic [1:0] {
        TEX_PAL4       = 2'b00,
        TEX_PAL8       = 2'b01,
        TEX_DIRECT     = 2'b10,
        TEX_DIRECT_ALT = 2'b11
    } texmode_e;

    // Row width from which the texture cache reloads within a row.
    localparam int unsigned CACHE_RELOAD_WIDTH = 32;

    // Largest of three widths, used to size shared arithmetic buses.
    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dce_height_adj.sv
// Module: dce_height_adj
// Produces the effective height used by rectangles and lines. Under
// interlaced skip the height is halved with a floor of one row.
// Assumes DIM_W >= 2. Purely combinational.
module dce_height_adj #(
    parameter int unsigned DIM_W = 11
) (
    input  logic [DIM_W-1:0] h_in,
    input  logic             skip,
    output logic [DIM_W-1:0] h_out
);

    localparam logic [DIM_W-1:0] ONE_ROW = DIM_W'(1);

    // Halve under skip, clamping a zero result up to one row.
    always_comb begin
        if (!skip) begin
            h_out = h_in;
        end else if (h_in[DIM_W-1:1] == '0) begin
            h_out = ONE_ROW;
        end else begin
            h_out = h_in >> 1;
        end
    end

endmodule

// File: rtl/dce_rect_cost.sv
// Module: dce_rect_cost
// Computes the rectangle cost: a per-row cost made of the width, a texture
// term that depends on the mode and on the cache reload width, and a
// half-width blend/mask term, multiplied by the effective height.
// Assumes DIM_W >= 6 so the reload width is representable. Combinational.
module dce_rect_cost
    import dce_pkg::*;
#(
    parameter int unsigned DIM_W  = 11,
    parameter int unsigned ROW_W  = DIM_W + 3,
    parameter int unsigned PROD_W = ROW_W + DIM_W
) (
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  h_eff,
    input  logic [1:0]        texmode,
    input  logic              textured,
    input  logic              penalty,
    output logic [ROW_W-1:0]  row_cost,
    output logic [PROD_W-1:0] total
);

    logic [ROW_W-1:0] w_x;
    logic [ROW_W-1:0] tex_add;
    logic [ROW_W-1:0] pen_add;
    logic             wide_row;

    assign w_x      = ROW_W'(width);
    assign wide_row = (w_x >= ROW_W'(CACHE_RELOAD_WIDTH));

    // Texture term per row, selected by colour mode and reload threshold.
    always_comb begin
        tex_add = '0;
        if (textured) begin
            case (texmode_e'(texmode))
                TEX_PAL4: tex_add = w_x;
                TEX_PAL8: tex_add = wide_row ? ((w_x >> 2) << 3) : w_x;
                default:  tex_add = wide_row ? ((w_x >> 1) << 3) : w_x;
            endcase
        end
    end

    // Blend or mask-check term: half the width rounded up.
    always_comb begin
        pen_add = penalty ? ((w_x + ROW_W'(1)) >> 1) : '0;
    end

    // Row cost and full product over the effective height.
    always_comb begin
        row_cost = w_x + tex_add + pen_add;
        total    = PROD_W'(row_cost) * PROD_W'(h_eff);
    end

endmodule

// File: rtl/dce_line_tri_cost.sv
// Module: dce_line_tri_cost
// Computes line cost (larger of width and effective height) and triangle
// cost (pixel count doubled when textured, plus half for blend/mask, then
// halved under interlaced skip). Assumes PIX_W >= 1. Combinational.
module dce_line_tri_cost #(
    parameter int unsigned DIM_W = 11,
    parameter int unsigned PIX_W = 20,
    parameter int unsigned TRI_W = PIX_W + 2
) (
    input  logic [DIM_W-1:0] width,
    input  logic [DIM_W-1:0] h_eff,
    input  logic [PIX_W-1:0] pixels,
    input  logic             textured,
    input  logic             penalty,
    input  logic             skip,
    output logic [DIM_W-1:0] line_cost,
    output logic [TRI_W-1:0] tri_cost
);

    logic [TRI_W-1:0] p_tex;
    logic [TRI_W-1:0] p_pen;

    // Line: dominant axis length.
    always_comb begin
        line_cost = (width > h_eff) ? width : h_eff;
    end

    // Triangle: apply the three adjustments in their fixed order.
    always_comb begin
        p_tex    = textured ? (TRI_W'(pixels) << 1) : TRI_W'(pixels);
        p_pen    = penalty ? (p_tex + ((p_tex + TRI_W'(1)) >> 1)) : p_tex;
        tri_cost = skip ? (p_pen >> 1) : p_pen;
    end

endmodule

// File: rtl/dce_countdown.sv
// Module: dce_countdown
// Holds busy while a loaded cycle count runs down. busy rises on the cycle
// after load, the counter decrements once per cycle, and busy falls on the
// cycle after the counter is seen at zero, giving count+1 busy cycles.
// Assumes load is only raised while busy is low.
module dce_countdown #(
    parameter int unsigned COUNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [COUNT_W-1:0] load_value,
    output logic               busy,
    output logic [COUNT_W-1:0] remaining
);

    // Load, decrement, and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            remaining <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            remaining <= load_value;
        end else if (busy) begin
            if (remaining == '0) begin
                busy <= 1'b0;
            end else begin
                remaining <= remaining - COUNT_W'(1);
            end
        end
    end

    // R10: a load starts a busy window holding the loaded value.
    p_load_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && remaining == $past(load_value)));

    // R11: every busy cycle with count left removes exactly one.
    p_decrement_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && remaining != '0) |=> (busy && remaining == $past(remaining) - COUNT_W'(1)));

    // R11: a zero count while busy releases on the next cycle.
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && remaining == '0) |=> !busy);

endmodule

// File: rtl/draw_cost_estimator.sv
// Module: draw_cost_estimator (top)
// Accepts one draw request at a time, computes its busy-cycle cost for the
// primitive kind, saturates it to COUNT_W bits, reports it with a one-cycle
// valid pulse and then holds busy for cost+1 cycles. Requests are refused
// while busy. Synchronous active-low reset.
module draw_cost_estimator
    import dce_pkg::*;
#(
    parameter int unsigned DIM_W   = 11,
    parameter int unsigned PIX_W   = 20,
    parameter int unsigned COUNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [DIM_W-1:0]   req_width,
    input  logic [DIM_W-1:0]   req_height,
    input  logic [PIX_W-1:0]   req_pixels,
    input  logic [1:0]         req_texmode,
    input  logic               req_textured,
    input  logic               req_blend,
    input  logic               req_mask_check,
    input  logic               req_interlace_skip,
    output logic               cost_valid,
    output logic [COUNT_W-1:0] cost_count,
    output logic               busy
);

    localparam int unsigned ROW_W  = DIM_W + 3;
    localparam int unsigned PROD_W = ROW_W + DIM_W;
    localparam int unsigned TRI_W  = PIX_W + 2;
    localparam int unsigned WIDE_W = max3(PROD_W, TRI_W, COUNT_W) + 1;
    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic [DIM_W-1:0]   h_eff;
    logic [ROW_W-1:0]   row_cost;
    logic [PROD_W-1:0]  rect_total;
    logic [DIM_W-1:0]   line_cost;
    logic [TRI_W-1:0]   tri_cost;
    logic [WIDE_W-1:0]  raw_cost;
    logic [COUNT_W-1:0] sat_cost;
    logic [COUNT_W-1:0] remaining;
    logic               penalty;
    logic               accept;

    assign penalty   = req_blend | req_mask_check;
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    dce_height_adj #(.DIM_W(DIM_W)) u_height (
        .h_in  (req_height),
        .skip  (req_interlace_skip),
        .h_out (h_eff)
    );

    dce_rect_cost #(.DIM_W(DIM_W), .ROW_W(ROW_W), .PROD_W(PROD_W)) u_rect (
        .width    (req_width),
        .h_eff    (h_eff),
        .texmode  (req_texmode),
        .textured (req_textured),
        .penalty  (penalty),
        .row_cost (row_cost),
        .total    (rect_total)
    );

    dce_line_tri_cost #(.DIM_W(DIM_W), .PIX_W(PIX_W), .TRI_W(TRI_W)) u_line_tri (
        .width     (req_width),
        .h_eff     (h_eff),
        .pixels    (req_pixels),
        .textured  (req_textured),
        .penalty   (penalty),
        .skip      (req_interlace_skip),
        .line_cost (line_cost),
        .tri_cost  (tri_cost)
    );

    // Select the cost for the requested primitive kind.
    always_comb begin
        case (prim_e'(req_kind))
            PRIM_RECT: raw_cost = WIDE_W'(rect_total);
            PRIM_LINE: raw_cost = WIDE_W'(line_cost);
            default:   raw_cost = WIDE_W'(tri_cost);
        endcase
    end

    // Clamp to the counter range.
    always_comb begin
        sat_cost = (raw_cost > WIDE_W'(CNT_MAX)) ? CNT_MAX : raw_cost[COUNT_W-1:0];
    end

    // Report register: one-cycle valid pulse with the accepted cost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cost_valid <= 1'b0;
            cost_count <= '0;
        end else begin
            cost_valid <= accept;
            if (accept) begin
                cost_count <= sat_cost;
            end
        end
    end

    dce_countdown #(.COUNT_W(COUNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_value (sat_cost),
        .busy       (busy),
        .remaining  (remaining)
    );

    // R10: the valid pulse lasts one cycle.
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |=> !cost_valid);

    // R10: a reported cost always coincides with a busy window.
    p_valid_with_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |-> busy);

    // R12: a request held during busy never produces a report.
    p_refuse_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> !cost_valid);

    // R6: interlaced skip never reduces a nonzero height to zero.
    p_height_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_interlace_skip && req_height != '0) |-> (h_eff != '0));

    // R9: the loaded count matches the reported count at the start.
    p_report_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cost_valid |-> (remaining == cost_count));

endmodule

// File: tb/draw_cost_estimator_test.sv
module draw_cost_estimator_test;

    localparam int CLK_PERIOD = 10;
    localparam int DIM_W      = 11;
    localparam int PIX_W      = 20;
    localparam int COUNT_W    = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [1:0]         req_kind = '0;
    logic [DIM_W-1:0]   req_width = '0;
    logic [DIM_W-1:0]   req_height = '0;
    logic [PIX_W-1:0]   req_pixels = '0;
    logic [1:0]         req_texmode = '0;
    logic               req_textured = 1'b0;
    logic               req_blend = 1'b0;
    logic               req_mask_check = 1'b0;
    logic               req_interlace_skip = 1'b0;
    logic               cost_valid;
    logic [COUNT_W-1:0] cost_count;
    logic               busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    draw_cost_estimator #(.DIM_W(DIM_W), .PIX_W(PIX_W), .COUNT_W(COUNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_width(req_width), .req_height(req_height),
        .req_pixels(req_pixels), .req_texmode(req_texmode), .req_textured(req_textured),
        .req_blend(req_blend), .req_mask_check(req_mask_check),
        .req_interlace_skip(req_interlace_skip), .cost_valid(cost_valid),
        .cost_count(cost_count), .busy(busy)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic set_req(input logic [1:0] kind, input int w, input int h, input int pix,
                           input logic [1:0] mode, input logic tex, input logic bl,
                           input logic mk, input logic sk);
        req_kind = kind; req_width = DIM_W'(w); req_height = DIM_W'(h);
        req_pixels = PIX_W'(pix); req_texmode = mode; req_textured = tex;
        req_blend = bl; req_mask_check = mk; req_interlace_skip = sk;
    endtask

    // One scenario: issue a request, check the reported cost and busy length.
    task automatic run_case(input string tag, input logic [1:0] kind, input int w, input int h,
                            input int pix, input logic [1:0] mode, input logic tex,
                            input logic bl, input logic mk, input logic sk, input int exp);
        int n;
        @(negedge clk);
        check({tag, " ready before request (R10)"}, req_ready, 1);
        set_req(kind, w, h, pix, mode, tex, bl, mk, sk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " cost_valid pulse (R10)"}, cost_valid, 1);
        check({tag, " cost value"}, cost_count, exp);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
            if (n == 1) check({tag, " single pulse (R10)"}, cost_valid, 0);
        end
        check({tag, " busy length (R11)"}, n, exp + 1);
        check({tag, " ready after busy (R11)"}, req_ready, 1);
    endtask

    // R12: requests held while busy are refused and do not disturb the countdown.
    task automatic refuse_case();
        int n;
        @(negedge clk);
        set_req(2'd0, 10, 2, 0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 first cost", cost_count, 20);
        n = 0;
        while (busy) begin
            n++;
            if (n == 3) begin
                set_req(2'd1, 5, 5, 0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
                req_valid = 1'b1;
            end
            if (n >= 4 && n <= 8) begin
                check("R12 ready low while busy", req_ready, 0);
                check("R12 no report while busy", cost_valid, 0);
            end
            if (n == 8) req_valid = 1'b0;
            @(negedge clk);
        end
        check("R12 busy length unchanged", n, 21);
        @(negedge clk);
        check("R12 refused request dropped", cost_valid, 0);
        check("R12 stays idle", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R13 busy in reset", busy, 0);
        check("R13 cost_valid in reset", cost_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 busy after reset", busy, 0);
        check("R13 ready after reset", req_ready, 1);
        check("R13 cost_count after reset", cost_count, 0);

        run_case("R1 plain rect 10x5",        2'd0, 10, 5, 0, 2'd0, 0, 0, 0, 0, 50);
        run_case("R2 pal4 rect 7x3",          2'd0, 7, 3, 0, 2'd0, 1, 0, 0, 0, 42);
        run_case("R2 untextured mode ignored",2'd0, 10, 6, 0, 2'd2, 0, 0, 0, 0, 60);
        run_case("R3 pal8 w31",               2'd0, 31, 2, 0, 2'd1, 1, 0, 0, 0, 124);
        run_case("R3 pal8 w32",               2'd0, 32, 2, 0, 2'd1, 1, 0, 0, 0, 192);
        run_case("R3 pal8 w33",               2'd0, 33, 1, 0, 2'd1, 1, 0, 0, 0, 97);
        run_case("R4 direct w33 mode2",       2'd0, 33, 1, 0, 2'd2, 1, 0, 0, 0, 161);
        run_case("R4 direct w20 mode3",       2'd0, 20, 2, 0, 2'd3, 1, 0, 0, 0, 80);
        run_case("R4 direct w32 mode3",       2'd0, 32, 1, 0, 2'd3, 1, 0, 0, 0, 160);
        run_case("R5 blend w9",               2'd0, 9, 4, 0, 2'd0, 0, 1, 0, 0, 56);
        run_case("R5 mask w9",                2'd0, 9, 4, 0, 2'd0, 0, 0, 1, 0, 56);
        run_case("R5 blend and mask w8",      2'd0, 8, 2, 0, 2'd0, 0, 1, 1, 0, 24);
        run_case("R6 skip rect h7",           2'd0, 10, 7, 0, 2'd0, 0, 0, 0, 1, 30);
        run_case("R6 skip rect h1 floor",     2'd0, 10, 1, 0, 2'd0, 0, 0, 0, 1, 10);
        run_case("R7 line wide",              2'd1, 12, 5, 0, 2'd0, 1, 1, 0, 0, 12);
        run_case("R7 line tall",              2'd1, 3, 40, 0, 2'd0, 0, 0, 0, 0, 40);
        run_case("R6 R7 line tall skip",      2'd1, 3, 40, 0, 2'd0, 0, 0, 0, 1, 20);
        run_case("R8 tri tex blend",          2'd2, 0, 0, 100, 2'd0, 1, 1, 0, 0, 300);
        run_case("R8 tri mask skip",          2'd2, 0, 0, 101, 2'd0, 0, 0, 1, 1, 76);
        run_case("R8 tri kind3 tex",          2'd3, 0, 0, 7, 2'd0, 1, 0, 0, 0, 14);
        run_case("R11 zero cost",             2'd0, 0, 5, 0, 2'd0, 0, 0, 0, 0, 0);
        refuse_case();
        run_case("R9 saturated rect",         2'd0, 2047, 2047, 0, 2'd0, 0, 0, 0, 0, 65535);

        summary();
        $finish;
    end

endmodule